// File: doc/BRIEF.md
# SDRAM Read Command Sequencer

This block turns one read request at a time (bank, row, starting column and a word count of one to eight halfwords) into an SDRAM command stream for a 16-bit device with a fixed burst of eight. It remembers which row is open in each bank. A request to a closed bank opens the row first. A request to the open row reads at once. A request to another row of an open bank closes that bank, reopens it and then reads. The spacing from row open to read and from precharge to row open comes from configuration inputs, given as cycle count minus one. The controller inserts NOP cycles until each spacing has passed.

After a read command the device bursts data while the block drives NOPs. The byte masks stay low for the requested words only. A valid strobe marks each requested word on the data bus. It starts a programmable CAS latency after the read command. When fewer than eight words are needed, the burst is cut off on the cycle right after the last requested word. The command used for this depends on the next access. A read is used when the next request is for the same open row. A precharge is used when the next request is for another row of the same bank. Otherwise the block issues a burst-terminate command.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is held, chip select, RAS, CAS and WE are all high, both mask lines are high, `rd_valid` is low and `req_ready` is high.
- R2: After reset, chip select stays low on every cycle. {RAS,CAS,WE} encodes activate=011, read=101, precharge=010, burst-terminate=110 and NOP=111.
- R3: A request to a closed bank issues activate with the request's bank on `sdr_ba` and its row on `sdr_addr`. The read command follows exactly `cfg_trcd`+1 cycles later, carrying the bank and the column (column in the low address bits).
- R4: Address bit 10 is low on every read and every precharge command.
- R5: Every command in the cycles after a read, up to the last requested word, is a NOP. Both mask lines are low from the read command through its last requested word cycle, and high on all other cycles.
- R6: `rd_valid` is high exactly from `cfg_cas_lat` cycles after a read command, for as many cycles as words were requested (word count = `req_len`+1), and low otherwise.
- R7: A request whose bank already has the same row open issues a read with no activate.
- R8: A request to an open bank with a different row issues precharge on that bank. Activate for the new row follows exactly `cfg_trp`+1 cycles later, and the read follows as in R3.
- R9: When N<8 words are requested with a read at cycle c, exactly one truncating command is issued at cycle c+N. It is a read for an already accepted request to the same bank and open row, a precharge for one to the same bank and another row, and a burst-terminate in every other case, including no pending request.
- R10: An eight-word read is followed by no truncating command. No command other than those in R3, R7, R8 and R9 is ever issued.
- R11: `req_ready` is low while an accepted request has not yet had its read issued. The first command for a request appears on the pins two cycles after the cycle in which `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cas_lat | input | 3 | CAS latency in cycles, 1 to 4 |
| cfg_trcd | input | 4 | Activate-to-read spacing minus one |
| cfg_trp | input | 4 | Precharge-to-activate spacing minus one |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request register free |
| req_bank | input | 2 | Request bank |
| req_row | input | 13 | Request row |
| req_col | input | 9 | Request starting column |
| req_len | input | 3 | Words requested minus one |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_ba | output | 2 | Bank address |
| sdr_addr | output | 13 | Row/column address |
| sdr_dqm_n | output | 2 | Byte masks, low while requested words are due |
| rd_valid | output | 1 | Data bus carries a requested word this cycle |

## Verification
Each command is expected on the pins at a fixed cycle offset. The first command comes one cycle after the accepting clock edge. A read comes `cfg_trcd`+1 cycles after its activate. An activate comes `cfg_trp`+1 cycles after a precharge. A truncating command comes N cycles after a read, and masks and `rd_valid` are due from the read cycle and from `cfg_cas_lat` cycles after it. For every request the driver computes these absolute cycle numbers from the accept cycle and queues them. The monitor samples the pins on the falling edge, half a cycle after each register update. There it pops and compares each non-NOP command and checks mask and strobe state on every cycle. Back-to-back requests are timed so the next one is accepted before the truncation point.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_PRE,
        CMD_BT
    } cmd_e;

    // {ras_n, cas_n, we_n} for each command, chip select low
    function automatic logic [2:0] cmd_pins(cmd_e c);
        case (c)
            CMD_ACT: return 3'b011;
            CMD_RD:  return 3'b101;
            CMD_PRE: return 3'b010;
            CMD_BT:  return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_en)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - TMR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // a spacing command may only start once the previous spacing has run out
    assert_load_when_expired_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (cnt_q == '0));

    // the wait shrinks by exactly one per idle cycle (R8 spacing)
    assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TMR_W'(1)));

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_en,
    input  logic              pre_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [BANK_W-1:0] q_bank,
    input  logic [ROW_W-1:0]  q_row,
    output logic              q_open,
    output logic              q_hit
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] vld_d, vld_q;
    logic [ROW_W-1:0] row_d [NBANK];
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_comb begin
            vld_d[g] = vld_q[g];
            row_d[g] = row_q[g];
            if (act_en && upd_bank == BANK_W'(g)) begin
                vld_d[g] = 1'b1;
                row_d[g] = upd_row;
            end else if (pre_en && upd_bank == BANK_W'(g)) begin
                vld_d[g] = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                row_q[g] <= '0;
            end else begin
                vld_q[g] <= vld_d[g];
                row_q[g] <= row_d[g];
            end
        end
    end

    assign q_open = vld_q[q_bank];
    assign q_hit  = vld_q[q_bank] && (row_q[q_bank] == q_row);

    // a row is only opened in a bank that is closed
    assert_act_on_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> !vld_q[upd_bank]);

    // a precharge only ever targets an open bank
    assert_pre_on_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> vld_q[upd_bank]);

endmodule

// File: rtl/sdram_rd_valid_pipe.sv
module sdram_rd_valid_pipe #(
    parameter int CL_MAX = 4,
    parameter int CL_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            burst_act,
    input  logic [CL_W-1:0] cas_lat,
    output logic            rd_valid
);
    logic [CL_MAX-1:0] sh_d, sh_q;

    always_comb begin
        sh_d     = {sh_q[CL_MAX-2:0], burst_act};
        rd_valid = 1'b0;
        for (int i = 0; i < CL_MAX; i++) begin
            if (cas_lat == CL_W'(i + 1)) rd_valid = sh_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // a one-cycle latency strobe echoes the mask state of the previous cycle
    assert_cl1_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat == CL_W'(1) && $stable(cas_lat)) |-> (rd_valid == sh_q[0]));

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdram_rd_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int ADDR_W    = 13,
    parameter int DQM_W     = 2,
    parameter int BURST_LEN = 8,
    parameter int CL_MAX    = 4,
    parameter int TMR_W     = 4,
    parameter int AP_BIT    = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(CL_MAX+1)-1:0]   cfg_cas_lat,
    input  logic [TMR_W-1:0]              cfg_trcd,
    input  logic [TMR_W-1:0]              cfg_trp,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [BANK_W-1:0]             req_bank,
    input  logic [ROW_W-1:0]              req_row,
    input  logic [COL_W-1:0]              req_col,
    input  logic [$clog2(BURST_LEN)-1:0]  req_len,
    output logic                          sdr_cs_n,
    output logic                          sdr_ras_n,
    output logic                          sdr_cas_n,
    output logic                          sdr_we_n,
    output logic [BANK_W-1:0]             sdr_ba,
    output logic [ADDR_W-1:0]             sdr_addr,
    output logic [DQM_W-1:0]              sdr_dqm_n,
    output logic                          rd_valid
);
    localparam int CL_W  = $clog2(CL_MAX + 1);
    localparam int CNT_W = $clog2(BURST_LEN + 1);
    localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST_LEN);

    typedef struct packed {
        logic              cur_vld;
        logic [BANK_W-1:0] cur_ba;
        logic [ROW_W-1:0]  cur_row;
        logic [COL_W-1:0]  cur_col;
        logic [CNT_W-1:0]  cur_n;
        logic [CNT_W-1:0]  cnt;     // cycles since last read, saturating
        logic [CNT_W-1:0]  plen;    // words owed by last read
        logic [BANK_W-1:0] pbank;   // bank of last read
        logic              cs_n;
        logic [2:0]        rcw;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
        logic              dqm_act;
    } st_t;

    st_t  d, q;
    cmd_e cmd;
    logic hold, live, same_bank;
    logic tmr_zero, q_open, q_hit;
    logic tmr_load;
    logic [TMR_W-1:0] tmr_val;

    always_comb begin
        d         = q;
        cmd       = CMD_NOP;
        hold      = q.cnt < q.plen;
        live      = q.cnt < BURST_C;
        same_bank = q.cur_vld && (q.cur_ba == q.pbank);

        if (!hold && tmr_zero) begin
            if (live) begin
                if (same_bank && q_hit)  cmd = CMD_RD;
                else if (same_bank)      cmd = CMD_PRE;
                else                     cmd = CMD_BT;
            end else if (q.cur_vld) begin
                if (q_hit)               cmd = CMD_RD;
                else if (q_open)         cmd = CMD_PRE;
                else                     cmd = CMD_ACT;
            end
        end

        if (req_valid && !q.cur_vld) begin
            d.cur_vld = 1'b1;
            d.cur_ba  = req_bank;
            d.cur_row = req_row;
            d.cur_col = req_col;
            d.cur_n   = CNT_W'(req_len) + CNT_W'(1);
        end

        if (live) d.cnt = q.cnt + CNT_W'(1);

        case (cmd)
            CMD_RD: begin
                d.cur_vld      = 1'b0;
                d.cnt          = CNT_W'(1);
                d.plen         = q.cur_n;
                d.pbank        = q.cur_ba;
                d.ba           = q.cur_ba;
                d.addr         = '0;
                d.addr[COL_W-1:0] = q.cur_col;
                d.addr[AP_BIT] = 1'b0;
            end
            CMD_ACT: begin
                d.ba           = q.cur_ba;
                d.addr         = '0;
                d.addr[ROW_W-1:0] = q.cur_row;
            end
            CMD_PRE: begin
                d.cnt          = BURST_C;
                d.ba           = q.cur_ba;
                d.addr[AP_BIT] = 1'b0;
            end
            CMD_BT: begin
                d.cnt          = BURST_C;
            end
            default: ;
        endcase

        d.cs_n    = 1'b0;
        d.rcw     = cmd_pins(cmd);
        d.dqm_act = (cmd == CMD_RD) || hold;

        tmr_load = (cmd == CMD_ACT) || (cmd == CMD_PRE);
        tmr_val  = (cmd == CMD_ACT) ? cfg_trcd : cfg_trp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cnt   <= BURST_C;
            q.cs_n  <= 1'b1;
            q.rcw   <= 3'b111;
        end else begin
            q <= d;
        end
    end

    sdram_cmd_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    sdram_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_en   (cmd == CMD_ACT),
        .pre_en   (cmd == CMD_PRE),
        .upd_bank (q.cur_ba),
        .upd_row  (q.cur_row),
        .q_bank   (q.cur_ba),
        .q_row    (q.cur_row),
        .q_open   (q_open),
        .q_hit    (q_hit)
    );

    sdram_rd_valid_pipe #(.CL_MAX(CL_MAX), .CL_W(CL_W)) u_vpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_act (q.dqm_act),
        .cas_lat   (cfg_cas_lat),
        .rd_valid  (rd_valid)
    );

    assign req_ready = !q.cur_vld;
    assign sdr_cs_n  = q.cs_n;
    assign sdr_ras_n = q.rcw[2];
    assign sdr_cas_n = q.rcw[1];
    assign sdr_we_n  = q.rcw[0];
    assign sdr_ba    = q.ba;
    assign sdr_addr  = q.addr;
    assign sdr_dqm_n = {DQM_W{~q.dqm_act}};

    // read and precharge never request auto/all-bank precharge
    assert_ap_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cs_n && (q.rcw == 3'b101 || q.rcw == 3'b010)) |-> !q.addr[AP_BIT]);

    // while requested words are still owed, the pins show NOP with masks low
    assert_nop_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (q.rcw == 3'b111) && q.dqm_act);

    // the cycle after the last owed word of a short burst carries a command
    assert_trunc_on_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.plen != '0 && q.cnt == q.plen && q.cnt < BURST_C) |=> (q.rcw != 3'b111));

endmodule

// File: tb/sdram_rd_seq_tb.sv
module sdram_rd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_BT  = 3'b110;
    localparam logic [2:0] C_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_cas_lat = 3'd3;
    logic [3:0]  cfg_trcd = 4'd2;
    logic [3:0]  cfg_trp = 4'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic [2:0]  req_len = '0;
    logic        sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n;
    logic [1:0]  sdr_ba;
    logic [12:0] sdr_addr;
    logic [1:0]  sdr_dqm_n;
    logic        rd_valid;

    sdram_rd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_trcd(cfg_trcd),
        .cfg_trp(cfg_trp), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .sdr_cs_n(sdr_cs_n), .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n),
        .sdr_we_n(sdr_we_n), .sdr_ba(sdr_ba), .sdr_addr(sdr_addr),
        .sdr_dqm_n(sdr_dqm_n), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int         cyc;
        logic [2:0] rcw;
        int         ba;
        int         addr;
        bit         chk_addr;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    bit   exp_dqm[int];
    bit   exp_val[int];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic exp_cmd(input int c, input logic [2:0] rcw, input int ba,
                           input int addr, input bit chk, input string tag);
        exp_t e;
        e.cyc = c; e.rcw = rcw; e.ba = ba; e.addr = addr; e.chk_addr = chk; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic exp_burst(input int r, input int n, input int cl);
        for (int i = 0; i < n; i++) begin
            exp_dqm[r + i] = 1'b1;
            exp_val[r + cl + i] = 1'b1;
        end
    endtask

    // monitor: pins are stable half a cycle after each rising edge
    always @(negedge clk) begin
        if (mon_on) begin
            logic [2:0] rcw;
            rcw = {sdr_ras_n, sdr_cas_n, sdr_we_n};
            check(sdr_cs_n == 1'b0, "R2", "chip select", sdr_cs_n, 0);
            check(sdr_dqm_n == (exp_dqm.exists(cyc) ? 2'b00 : 2'b11), "R5", "dqm",
                  sdr_dqm_n, exp_dqm.exists(cyc) ? 0 : 3);
            check(rd_valid == exp_val.exists(cyc), "R6", "rd_valid",
                  rd_valid, exp_val.exists(cyc));
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                check(1'b0, exp_q[0].tag, "missing command code", C_NOP, exp_q[0].rcw);
                void'(exp_q.pop_front());
            end
            if (rcw != C_NOP) begin
                if (rcw == C_RD || rcw == C_PRE)
                    check(sdr_addr[10] == 1'b0, "R4", "address bit 10", sdr_addr[10], 0);
                if (exp_q.size() == 0 || exp_q[0].cyc != cyc) begin
                    check(1'b0, "R10", "unexpected command code", rcw, C_NOP);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rcw == e.rcw, e.tag, "command code", rcw, e.rcw);
                    if (e.rcw != C_BT)
                        check(int'(sdr_ba) == e.ba, e.tag, "bank", sdr_ba, e.ba);
                    if (e.chk_addr)
                        check(int'(sdr_addr) == e.addr, e.tag, "address", sdr_addr, e.addr);
                end
            end
        end
    end

    task automatic send(input int b, input int row, input int col, input int len,
                        output int acc);
        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = 2'(b);
        req_row   = 13'(row);
        req_col   = 9'(col);
        req_len   = 3'(len);
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        check(req_ready == 1'b0, "R11", "req_ready while held", req_ready, 0);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        int a, b, r;
        repeat (3) @(negedge clk);
        check(sdr_cs_n && sdr_ras_n && sdr_cas_n && sdr_we_n, "R1", "reset command pins",
              {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}, 15);
        check(sdr_dqm_n == 2'b11, "R1", "reset dqm", sdr_dqm_n, 3);
        check(rd_valid == 1'b0, "R1", "reset rd_valid", rd_valid, 0);
        check(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        idle(2);

        // S1: closed bank, 4 words, burst-terminate truncation (R3 R9)
        send(0, 5, 8, 3, a);
        exp_cmd(a + 1, C_ACT, 0, 5, 1, "R3");
        r = a + 4;
        exp_cmd(r, C_RD, 0, 8, 1, "R3");
        exp_burst(r, 4, 3);
        exp_cmd(r + 4, C_BT, 0, 0, 0, "R9");
        idle(20);

        // S2: open row hit, full burst (R7 R10)
        send(0, 5, 16, 7, a);
        r = a + 1;
        exp_cmd(r, C_RD, 0, 16, 1, "R7");
        exp_burst(r, 8, 3);
        idle(20);

        // S3: row miss: precharge, activate, read (R8)
        send(0, 9, 0, 1, a);
        exp_cmd(a + 1, C_PRE, 0, 0, 0, "R8");
        exp_cmd(a + 3, C_ACT, 0, 9, 1, "R8");
        r = a + 6;
        exp_cmd(r, C_RD, 0, 0, 1, "R8");
        exp_burst(r, 2, 3);
        exp_cmd(r + 2, C_BT, 0, 0, 0, "R9");
        idle(20);

        // S4: truncation by a new read to the same open row (R9)
        send(1, 3, 0, 2, a);
        exp_cmd(a + 1, C_ACT, 1, 3, 1, "R3");
        r = a + 4;
        exp_cmd(r, C_RD, 1, 0, 1, "R3");
        exp_burst(r, 3, 3);
        send(1, 3, 32, 1, b);
        check(b == r + 1, "R11", "accept cycle after read", b, r + 1);
        exp_cmd(r + 3, C_RD, 1, 32, 1, "R9");
        exp_burst(r + 3, 2, 3);
        exp_cmd(r + 5, C_BT, 0, 0, 0, "R9");
        idle(20);

        // S5: truncation by precharge for another row of the same bank (R9 R8)
        send(1, 3, 0, 1, a);
        r = a + 1;
        exp_cmd(r, C_RD, 1, 0, 1, "R7");
        exp_burst(r, 2, 3);
        send(1, 7, 64, 0, b);
        exp_cmd(r + 2, C_PRE, 1, 0, 0, "R9");
        exp_cmd(r + 4, C_ACT, 1, 7, 1, "R8");
        exp_cmd(r + 7, C_RD, 1, 64, 1, "R8");
        exp_burst(r + 7, 1, 3);
        exp_cmd(r + 8, C_BT, 0, 0, 0, "R9");
        idle(20);

        // S6: burst-terminate before another bank, then a full burst there (R9 R10)
        send(1, 7, 8, 1, a);
        r = a + 1;
        exp_cmd(r, C_RD, 1, 8, 1, "R7");
        exp_burst(r, 2, 3);
        send(2, 1, 0, 7, b);
        exp_cmd(r + 2, C_BT, 0, 0, 0, "R9");
        exp_cmd(r + 3, C_ACT, 2, 1, 1, "R3");
        exp_cmd(r + 6, C_RD, 2, 0, 1, "R10");
        exp_burst(r + 6, 8, 3);
        idle(20);

        // S7: CAS latency of two (R6)
        cfg_cas_lat = 3'd2;
        send(2, 1, 4, 2, a);
        r = a + 1;
        exp_cmd(r, C_RD, 2, 4, 1, "R6");
        exp_burst(r, 3, 2);
        exp_cmd(r + 3, C_BT, 0, 0, 0, "R9");
        idle(20);

        check(exp_q.size() == 0, "R10", "commands never seen", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", cyc, 0);
        finish_run();
    end

endmodule